// File: doc/BRIEF.md
# Accumulator and Extension-Flag Operation Unit

This block holds a machine's working accumulator (AC, 16 bits by default) and the one-bit extension flag E that catches the adder's carry and takes part in rotations. It executes two kinds of work. The first kind is data-path operations that take an operand register value (DR) or the 8-bit input character (INPR): bitwise AND, add with carry out, load, and input of a character into the low byte. The second kind is the register-reference group. In that group a single execute strobe, raised by the sequencer in the third timing step of such an instruction, comes with the twelve low instruction bits. Exactly one of those bits is set, and it picks one operation.

The register-reference group covers these operations: clear AC or E, complement AC or E, rotate right or left through E, increment AC, four skip tests, and a stop request. Every AC or E update takes effect at the clock edge that ends the execute cycle. The skip and stop outputs are combinational during that cycle. The sequencer uses skip to advance its program counter and stop to clear its run flip-flop. The sequencer keeps the control strobes one-hot. The unit still defines which strobe wins when a register-reference strobe and a data-path strobe arrive together.

Top module: `accum_regop_unit`

## Requirements
- R1: After a synchronous active-low reset, AC is 0 and E is 0. With no strobe active, skip and stop are both 0.
- R2: When add_stb is set, AC takes the low 16 bits of AC+DR and E takes the carry out of bit 15. Both take effect at the next clock edge.
- R3: When and_stb is set, AC takes AC AND DR, and E keeps its value.
- R4: When load_stb is set, AC takes DR, and E keeps its value.
- R5: When inp_stb is set, AC bits 7..0 take INPR, while AC bits 15..8 and E keep their values.
- R6: With rr_exec set, rr_sel bit 11 clears AC and rr_sel bit 10 clears E. In each case the other register keeps its value.
- R7: With rr_exec set, rr_sel bit 9 inverts every bit of AC and rr_sel bit 8 inverts E.
- R8: With rr_exec set, rr_sel bit 7 rotates right through E. AC bit 15 takes the old E, AC bits 14..0 take old AC bits 15..1, and E takes old AC bit 0.
- R9: With rr_exec set, rr_sel bit 6 rotates left through E. AC bit 0 takes the old E, AC bits 15..1 take old AC bits 14..0, and E takes old AC bit 15.
- R10: With rr_exec set, rr_sel bit 5 adds 1 to AC modulo 2^16, and E keeps its value.
- R11: With rr_exec set, skip is 1 in that same cycle when the selected test holds on the current AC and E. The tests are: bit 4, AC bit 15 is 0; bit 3, AC bit 15 is 1; bit 2, AC is zero; bit 1, E is 0. A skip test leaves AC and E unchanged.
- R12: With rr_exec set and rr_sel bit 0 set, the stop output is 1 in that cycle, and AC and E keep their values.
- R13: When rr_exec is set in the same cycle as any data-path strobe, the register-reference operation takes effect and the data-path strobe has no effect.
- R14: When rr_exec is 0 and no data-path strobe is set, AC and E hold, and skip and stop stay 0 whatever rr_sel carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| and_stb | input | 1 | Data-path strobe: AC AND DR |
| add_stb | input | 1 | Data-path strobe: AC plus DR, carry to E |
| load_stb | input | 1 | Data-path strobe: AC from DR |
| inp_stb | input | 1 | Data-path strobe: AC low byte from INPR |
| rr_exec | input | 1 | Register-reference execute cycle |
| rr_sel | input | 12 | One-hot operation select (instruction bits 11..0) |
| dr_val | input | 16 | Operand register value |
| inpr_val | input | 8 | Input character |
| acc_q | output | 16 | Accumulator |
| ext_q | output | 1 | Extension flag E |
| skip | output | 1 | Skip condition met (combinational) |
| stop | output | 1 | Stop request (combinational) |

## Verification
Two functions can land in the same cycle. The first case is a register-reference execute arriving together with a data-path strobe. The bench provokes it by raising rr_exec with a clear, a rotate or a skip test while add_stb or load_stb is also high. It judges the result by checking that AC and E after the edge match the register-reference result alone. The second case is a skip test issued in the cycle right after a load or add. Here the bench checks that skip is judged on the freshly written AC, and that the test itself leaves AC and E untouched.

// File: rtl/accop_pkg.sv
// Package accop_pkg
// Purpose: shared operation codes and select-bit positions for the
//          accumulator unit.
// Assumes: the select-bit positions are fixed by the instruction format.
package accop_pkg;

    // Data-path operation after strobe decode
    typedef enum logic [2:0] {
        DP_IDLE = 3'd0,
        DP_AND  = 3'd1,
        DP_ADD  = 3'd2,
        DP_LOAD = 3'd3,
        DP_INP  = 3'd4
    } dp_op_e;

    localparam int RR_BITS       = 12;
    localparam int BIT_CLR_AC    = 11;
    localparam int BIT_CLR_E     = 10;
    localparam int BIT_NOT_AC    = 9;
    localparam int BIT_NOT_E     = 8;
    localparam int BIT_ROT_R     = 7;
    localparam int BIT_ROT_L     = 6;
    localparam int BIT_INCR      = 5;
    localparam int BIT_SKIP_POS  = 4;
    localparam int BIT_SKIP_NEG  = 3;
    localparam int BIT_SKIP_ZERO = 2;
    localparam int BIT_SKIP_EZ   = 1;
    localparam int BIT_STOP      = 0;

    localparam int SKIP_TESTS    = 4;

endpackage

// File: rtl/accop_datapath.sv
// Module accop_datapath
// Purpose: adder-and-logic circuit for the data-path operations (AND,
//          ADD with carry, load, character input). Purely combinational.
// Assumes: IN_W < W; op is already decoded with priority by the parent.
module accop_datapath
    import accop_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic [W-1:0]    acc,
    input  logic            ext,
    input  logic [W-1:0]    dr,
    input  logic [IN_W-1:0] inpr,
    input  dp_op_e          op,
    output logic [W-1:0]    nxt_acc,
    output logic            nxt_ext,
    output logic            dp_we
);

    localparam int SUM_W = W + 1;

    logic [SUM_W-1:0] sum;

    // Full-width adder with carry out in the top bit
    always_comb begin
        sum = {1'b0, acc} + {1'b0, dr};
    end

    // Choose the result for the decoded operation
    always_comb begin
        nxt_acc = acc;
        nxt_ext = ext;
        dp_we   = 1'b1;
        case (op)
            DP_AND:  nxt_acc = acc & dr;
            DP_ADD:  begin
                nxt_acc = sum[W-1:0];
                nxt_ext = sum[W];
            end
            DP_LOAD: nxt_acc = dr;
            DP_INP:  nxt_acc = {acc[W-1:IN_W], inpr};
            default: dp_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/accop_regref.sv
// Module accop_regref
// Purpose: register-reference operations on AC and E, the skip tests
//          and the stop request.
// Assumes: sel is one-hot while exec is high. When several bits are set,
//          the highest modifying bit wins (the result is undefined by the
//          instruction set).
module accop_regref
    import accop_pkg::*;
#(
    parameter int W = 16
) (
    input  logic               exec,
    input  logic [RR_BITS-1:0] sel,
    input  logic [W-1:0]       acc,
    input  logic               ext,
    output logic [W-1:0]       nxt_acc,
    output logic               nxt_ext,
    output logic               rr_we,
    output logic               skip,
    output logic               stop
);

    localparam int MSB = W - 1;

    logic [SKIP_TESTS-1:0] cond;
    logic [SKIP_TESTS-1:0] pick;

    // Skip conditions, index k matches select bit k+1
    always_comb begin
        cond[BIT_SKIP_EZ   - 1] = ~ext;
        cond[BIT_SKIP_ZERO - 1] = (acc == '0);
        cond[BIT_SKIP_NEG  - 1] = acc[MSB];
        cond[BIT_SKIP_POS  - 1] = ~acc[MSB];
    end

    // Gate each test with its select bit
    genvar k;
    generate
        for (k = 0; k < SKIP_TESTS; k++) begin : g_skip
            assign pick[k] = cond[k] & sel[k + 1];
        end
    endgenerate

    // Skip and stop are valid only during the execute cycle
    always_comb begin
        skip = exec & (|pick);
        stop = exec & sel[BIT_STOP];
    end

    // Next AC/E for the modifying operations
    always_comb begin
        nxt_acc = acc;
        nxt_ext = ext;
        rr_we   = exec;
        if (sel[BIT_CLR_AC]) begin
            nxt_acc = '0;
        end else if (sel[BIT_CLR_E]) begin
            nxt_ext = 1'b0;
        end else if (sel[BIT_NOT_AC]) begin
            nxt_acc = ~acc;
        end else if (sel[BIT_NOT_E]) begin
            nxt_ext = ~ext;
        end else if (sel[BIT_ROT_R]) begin
            nxt_acc = {ext, acc[MSB:1]};
            nxt_ext = acc[0];
        end else if (sel[BIT_ROT_L]) begin
            nxt_acc = {acc[MSB-1:0], ext};
            nxt_ext = acc[MSB];
        end else if (sel[BIT_INCR]) begin
            nxt_acc = acc + 1'b1;
        end
    end

endmodule

// File: rtl/accop_state.sv
// Module accop_state
// Purpose: AC and E storage. It takes the register-reference result ahead
//          of the data-path result.
// Assumes: synchronous active-low reset; the write enables come from the
//          two operation modules.
module accop_state #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rr_we,
    input  logic [W-1:0] rr_acc,
    input  logic         rr_ext,
    input  logic         dp_we,
    input  logic [W-1:0] dp_acc,
    input  logic         dp_ext,
    output logic [W-1:0] acc,
    output logic         ext
);

    // Register update with register-reference priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            ext <= 1'b0;
        end else if (rr_we) begin
            acc <= rr_acc;
            ext <= rr_ext;
        end else if (dp_we) begin
            acc <= dp_acc;
            ext <= dp_ext;
        end
    end

    // With no write enable, AC and E hold their values
    p_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_we && !dp_we) |=> ($stable(acc) && $stable(ext)))
        else $error("p_hold_r14");

endmodule

// File: rtl/accum_regop_unit.sv
// Module accum_regop_unit
// Purpose: accumulator with extension flag. It decodes the sequencer
//          strobes and runs data-path and register-reference operations.
// Assumes: strobes are normally one-hot; rr_exec wins over data strobes.
module accum_regop_unit
    import accop_pkg::*;
#(
    parameter int W    = 16,
    parameter int IN_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               and_stb,
    input  logic               add_stb,
    input  logic               load_stb,
    input  logic               inp_stb,
    input  logic               rr_exec,
    input  logic [RR_BITS-1:0] rr_sel,
    input  logic [W-1:0]       dr_val,
    input  logic [IN_W-1:0]    inpr_val,
    output logic [W-1:0]       acc_q,
    output logic               ext_q,
    output logic               skip,
    output logic               stop
);

    localparam int MSB = W - 1;

    dp_op_e       dp_op;
    logic [W-1:0] dp_acc, rr_acc;
    logic         dp_ext, rr_ext, dp_we, rr_we;

    // Strobe decode; register-reference execute blocks data strobes
    always_comb begin
        if (rr_exec)       dp_op = DP_IDLE;
        else if (add_stb)  dp_op = DP_ADD;
        else if (and_stb)  dp_op = DP_AND;
        else if (load_stb) dp_op = DP_LOAD;
        else if (inp_stb)  dp_op = DP_INP;
        else               dp_op = DP_IDLE;
    end

    accop_datapath #(.W(W), .IN_W(IN_W)) u_dp (
        .acc     (acc_q),
        .ext     (ext_q),
        .dr      (dr_val),
        .inpr    (inpr_val),
        .op      (dp_op),
        .nxt_acc (dp_acc),
        .nxt_ext (dp_ext),
        .dp_we   (dp_we)
    );

    accop_regref #(.W(W)) u_rr (
        .exec    (rr_exec),
        .sel     (rr_sel),
        .acc     (acc_q),
        .ext     (ext_q),
        .nxt_acc (rr_acc),
        .nxt_ext (rr_ext),
        .rr_we   (rr_we),
        .skip    (skip),
        .stop    (stop)
    );

    accop_state #(.W(W)) u_st (
        .clk    (clk),
        .rst_n  (rst_n),
        .rr_we  (rr_we),
        .rr_acc (rr_acc),
        .rr_ext (rr_ext),
        .dp_we  (dp_we),
        .dp_acc (dp_acc),
        .dp_ext (dp_ext),
        .acc    (acc_q),
        .ext    (ext_q)
    );

    // Add places the sum in AC and the carry in E
    p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (add_stb && !rr_exec) |=>
            ({ext_q, acc_q} == ({1'b0, $past(acc_q)} + {1'b0, $past(dr_val)})))
        else $error("p_add_r2");

    // Rotate right moves E into the MSB and bit 0 into E
    p_rotr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_exec && rr_sel == (RR_BITS'(1) << BIT_ROT_R)) |=>
            (acc_q == {$past(ext_q), $past(acc_q[MSB:1])} && ext_q == $past(acc_q[0])))
        else $error("p_rotr_r8");

    // Rotate left moves E into bit 0 and the MSB into E
    p_rotl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_exec && rr_sel == (RR_BITS'(1) << BIT_ROT_L)) |=>
            (acc_q == {$past(acc_q[MSB-1:0]), $past(ext_q)} && ext_q == $past(acc_q[MSB])))
        else $error("p_rotl_r9");

    // Increment wraps modulo 2^W and keeps E
    p_incr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_exec && rr_sel == (RR_BITS'(1) << BIT_INCR)) |=>
            (acc_q == W'($past(acc_q) + 1'b1) && $stable(ext_q)))
        else $error("p_incr_r10");

    // A stop request leaves AC and E untouched
    p_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> ($stable(acc_q) && $stable(ext_q)))
        else $error("p_stop_r12");

endmodule

// File: tb/test_accum_regop_unit.sv
`timescale 1ns/1ps
module test_accum_regop_unit;

    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        and_stb = 0, add_stb = 0, load_stb = 0, inp_stb = 0;
    logic        rr_exec = 0;
    logic [11:0] rr_sel = '0;
    logic [15:0] dr_val = '0;
    logic [7:0]  inpr_val = '0;
    logic [15:0] acc_q;
    logic        ext_q, skip, stop;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_ac;
    logic        m_e;

    always #2.5 clk = ~clk;

    accum_regop_unit i_accum_regop_unit (
        .clk(clk), .rst_n(rst_n),
        .and_stb(and_stb), .add_stb(add_stb), .load_stb(load_stb), .inp_stb(inp_stb),
        .rr_exec(rr_exec), .rr_sel(rr_sel), .dr_val(dr_val), .inpr_val(inpr_val),
        .acc_q(acc_q), .ext_q(ext_q), .skip(skip), .stop(stop)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(req, {16'd0, acc_q}, {16'd0, m_ac});
        chk(req, {31'd0, ext_q}, {31'd0, m_e});
    endtask

    // One data-path cycle: kind 0 and, 1 add, 2 load, 3 inp
    task automatic dp_cycle(input int kind, input logic [15:0] d, input logic [7:0] c);
        logic [16:0] s;
        @(negedge clk);
        dr_val = d; inpr_val = c;
        and_stb = (kind == 0); add_stb = (kind == 1);
        load_stb = (kind == 2); inp_stb = (kind == 3);
        case (kind)
            0: m_ac = m_ac & d;
            1: begin s = {1'b0, m_ac} + {1'b0, d}; m_ac = s[15:0]; m_e = s[16]; end
            2: m_ac = d;
            default: m_ac = {m_ac[15:8], c};
        endcase
        @(posedge clk); #1;
        and_stb = 0; add_stb = 0; load_stb = 0; inp_stb = 0;
    endtask

    // One register-reference cycle on select bit idx; check skip/stop mid-cycle
    task automatic rr_cycle(input int idx, input logic exp_skip, input string req);
        logic [15:0] a;
        logic        e;
        @(negedge clk);
        rr_exec = 1; rr_sel = 12'(1) << idx;
        #1;
        chk(req, {31'd0, skip}, {31'd0, exp_skip});
        chk(req, {31'd0, stop}, {31'd0, (idx == 0)});
        a = m_ac; e = m_e;
        case (idx)
            11: m_ac = '0;
            10: m_e = 1'b0;
            9:  m_ac = ~a;
            8:  m_e = ~e;
            7:  begin m_ac = {e, a[15:1]}; m_e = a[0]; end
            6:  begin m_ac = {a[14:0], e}; m_e = a[15]; end
            5:  m_ac = a + 16'd1;
            default: ;
        endcase
        @(posedge clk); #1;
        rr_exec = 0; rr_sel = '0;
        chk_state(req);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        #1;
        m_ac = '0; m_e = 0;
        chk_state("R1 reset state");
        chk("R1 skip", {31'd0, skip}, 0);
        chk("R1 stop", {31'd0, stop}, 0);
        @(negedge clk); rst_n = 1;
    endtask

    task automatic t_load_and;
        dp_cycle(2, 16'hA5C3, 8'h00); chk_state("R4 load");
        dp_cycle(0, 16'h0FF0, 8'h00); chk_state("R3 and");
        dp_cycle(0, 16'hFFFF, 8'h00); chk_state("R3 and all ones");
    endtask

    task automatic t_add;
        dp_cycle(2, 16'h1234, 8'h00);
        dp_cycle(1, 16'h0101, 8'h00); chk_state("R2 add no carry");
        dp_cycle(2, 16'hFFFF, 8'h00);
        dp_cycle(1, 16'h0002, 8'h00); chk_state("R2 add carry");
        dp_cycle(1, 16'h0000, 8'h00); chk_state("R2 add clears carry");
    endtask

    task automatic t_inp;
        dp_cycle(2, 16'hBEEF, 8'h00);
        dp_cycle(3, 16'h0000, 8'h5A); chk_state("R5 input low byte");
    endtask

    task automatic t_clear_comp;
        dp_cycle(2, 16'hFFFF, 8'h00);
        dp_cycle(1, 16'h0001, 8'h00);
        dp_cycle(2, 16'h3C3C, 8'h00);
        rr_cycle(9, 0, "R7 invert AC");
        rr_cycle(8, 0, "R7 invert E");
        rr_cycle(8, 0, "R7 invert E back");
        rr_cycle(11, 0, "R6 clear AC");
        rr_cycle(10, 0, "R6 clear E");
    endtask

    task automatic t_rotate;
        dp_cycle(2, 16'h8001, 8'h00);
        rr_cycle(7, 0, "R8 rotate right");
        rr_cycle(7, 0, "R8 rotate right with E set");
        rr_cycle(6, 0, "R9 rotate left");
        rr_cycle(6, 0, "R9 rotate left again");
    endtask

    task automatic t_incr;
        dp_cycle(2, 16'h00FF, 8'h00);
        rr_cycle(5, 0, "R10 increment");
        dp_cycle(2, 16'hFFFF, 8'h00);
        rr_cycle(5, 0, "R10 increment wrap");
    endtask

    task automatic t_skips;
        dp_cycle(2, 16'h0000, 8'h00);
        rr_cycle(10, 0, "R11 setup");
        rr_cycle(2, 1, "R11 zero test true after load");
        rr_cycle(4, 1, "R11 positive test true");
        rr_cycle(3, 0, "R11 negative test false");
        rr_cycle(1, 1, "R11 E-zero test true");
        dp_cycle(2, 16'h8000, 8'h00);
        rr_cycle(3, 1, "R11 negative test true");
        rr_cycle(4, 0, "R11 positive test false");
        rr_cycle(2, 0, "R11 zero test false");
        rr_cycle(8, 0, "R11 setup E");
        rr_cycle(1, 0, "R11 E-zero test false");
    endtask

    task automatic t_stop;
        dp_cycle(2, 16'h7777, 8'h00);
        rr_cycle(0, 0, "R12 stop");
    endtask

    task automatic t_collision;
        dp_cycle(2, 16'h1111, 8'h00);
        @(negedge clk);
        rr_exec = 1; rr_sel = 12'(1) << 11; add_stb = 1; dr_val = 16'h2222;
        m_ac = '0;
        @(posedge clk); #1;
        rr_exec = 0; rr_sel = '0; add_stb = 0;
        chk_state("R13 clear wins over add");
        @(negedge clk);
        rr_exec = 1; rr_sel = 12'(1) << 2; load_stb = 1; dr_val = 16'h4444;
        #1 chk("R13 skip with load", {31'd0, skip}, 1);
        @(posedge clk); #1;
        rr_exec = 0; rr_sel = '0; load_stb = 0;
        chk_state("R13 load ignored under skip test");
    endtask

    task automatic t_idle_sel;
        dp_cycle(2, 16'h0000, 8'h00);
        @(negedge clk);
        rr_sel = 12'hFFF;
        #1;
        chk("R14 skip idle", {31'd0, skip}, 0);
        chk("R14 stop idle", {31'd0, stop}, 0);
        @(posedge clk); #1;
        rr_sel = '0;
        chk_state("R14 hold without strobes");
    endtask

    initial begin
        t_reset();
        t_load_and();
        t_add();
        t_inp();
        t_clear_comp();
        t_rotate();
        t_incr();
        t_skips();
        t_stop();
        t_collision();
        t_idle_sel();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule